// File: doc/BRIEF.md
# Nibble-Wide Cell Port With Frame Pulse

This block is one port of a dedicated 4-bit cell interface. Cells of 53 bytes travel as 106 nibbles, high nibble of each byte first, and each cell is announced by a one-cycle frame pulse in the transfer cycle just before its first nibble. Flow control works by gating the transfer clock, not through a ready line. In this design the gated clocks are expressed as per-cycle enables of the single free-running clock `clk`. `tx_pull` high means a transmit clock edge happens at the next rising edge of `clk`. `rx_take` high means the attached device is cycling its receive clock in that cycle.

On the transmit side, the transmit machine has three states. In `TX_HUNT` it waits for a frame pulse and ignores nibbles. A frame moves it to `TX_FILL`, where it collects nibbles into a one-cell buffer. After the 106th nibble it moves to `TX_FULL`. There it stops pulling and hands the bytes to the line side over a valid/ready handshake. After the last byte it returns to `TX_HUNT`. A frame seen in `TX_FILL` restarts the count at nibble zero.

On the receive side, the receive machine also has three states. In `RX_LOAD` it accepts 53 bytes from the line side, then moves to `RX_FRAME`. On the next take cycle it emits the frame pulse and moves to `RX_SEND`. There every further take cycle delivers one nibble. After nibble 106 it returns to `RX_LOAD`.

Top module: `nibble_cell_port`

## Requirements
- R1: After reset, `tx_pull` and `line_rx_ready` are 1, and `line_tx_valid`, `rx_frame` and `rx_nib_vld` are 0.
- R2: In `TX_HUNT`, nibbles pulled with `tx_frame` low have no effect on the next cell delivered to the line side.
- R3: After a pull cycle with `tx_frame`=1, the next 106 pull cycles carry the cell. Byte k on the line side is {nibble 2k, nibble 2k+1}, with the high nibble first.
- R4: `tx_pull` is 0 from the cycle after the 106th nibble until the last byte is drained. `tx_frame` and `tx_nib` have no effect during that time.
- R5: Bytes leave in order on `line_tx_data` while `line_tx_valid` is 1. A byte moves when `line_tx_ready` is 1. While valid is 1 and ready is 0, the data is held stable.
- R6: A frame pulse on a pull cycle in `TX_FILL` restarts the cell at nibble 0.
- R7: `line_rx_ready` is 1 in `RX_LOAD` only. After 53 bytes it drops, and bytes offered while it is 0 are ignored.
- R8: `rx_frame` is 1 only in a take cycle after a full cell is buffered. It lasts exactly one take cycle, and no nibble is delivered in that cycle.
- R9: Each take cycle after the frame presents the next nibble on `rx_nib` with `rx_nib_vld`=1, high nibble of each byte first. A cycle without `rx_take` advances nothing and shows `rx_nib_vld`=0.
- R10: After the 106th nibble is taken, `line_rx_ready` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_pull | output | 1 | Transmit clock enable: a nibble is taken at the next edge |
| tx_frame | input | 1 | Transmit frame pulse, one pull cycle before the cell |
| tx_nib | input | 4 | Transmit nibble |
| line_tx_valid | output | 1 | Buffered cell byte available to the line side |
| line_tx_ready | input | 1 | Line side accepts the byte |
| line_tx_data | output | 8 | Cell byte toward the line |
| line_rx_valid | input | 1 | Line side offers a received byte |
| line_rx_ready | output | 1 | Receive buffer accepts bytes |
| line_rx_data | input | 8 | Received cell byte |
| rx_take | input | 1 | Attached device cycles its receive clock this cycle |
| rx_frame | output | 1 | Receive frame pulse |
| rx_nib_vld | output | 1 | `rx_nib` carries a cell nibble this take cycle |
| rx_nib | output | 4 | Receive nibble |

## Verification
The assertions check on every cycle that pulling stops while the transmit buffer drains, and that a stalled byte stays put. They also check that the receive frame pulse appears only on a take cycle, never twice in a row, never together with a nibble, and never while bytes are still being loaded. Only the bench scenarios can show that cells come out with the right nibble order and byte content. The same holds for ignoring nibbles before a frame, realigning on a second frame, and the receive buffer reopening after exactly 106 nibbles.

// File: rtl/nibble_cell_pkg.sv
package nibble_cell_pkg;
    typedef enum logic [1:0] {
        TX_HUNT = 2'd0,
        TX_FILL = 2'd1,
        TX_FULL = 2'd2
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_LOAD  = 2'd0,
        RX_FRAME = 2'd1,
        RX_SEND  = 2'd2
    } rx_state_e;
endpackage

// File: rtl/nibble_cell_tx.sv
module nibble_cell_tx
    import nibble_cell_pkg::*;
#(
    parameter int NIB_W     = 4,
    parameter int CELL_NIBS = 106
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic               tx_pull,
    input  logic               tx_frame,
    input  logic [NIB_W-1:0]   tx_nib,
    output logic               line_tx_valid,
    input  logic               line_tx_ready,
    output logic [2*NIB_W-1:0] line_tx_data
);
    localparam int BYTE_W     = 2 * NIB_W;
    localparam int CELL_BYTES = CELL_NIBS / 2;
    localparam int NW         = $clog2(CELL_NIBS);
    localparam int BW         = $clog2(CELL_BYTES);
    localparam logic [NW-1:0] LAST_NIB  = NW'(CELL_NIBS - 1);
    localparam logic [BW-1:0] LAST_BYTE = BW'(CELL_BYTES - 1);

    tx_state_e         st, st_nxt;
    logic [NW-1:0]     nib_cnt;
    logic [BW-1:0]     rd_idx;
    logic [NIB_W-1:0]  hi_hold;
    logic [BYTE_W-1:0] buf_mem [CELL_BYTES];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= TX_HUNT;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            TX_HUNT: if (tx_pull && tx_frame) st_nxt = TX_FILL;
            TX_FILL: if (tx_pull && !tx_frame && nib_cnt == LAST_NIB) st_nxt = TX_FULL;
            TX_FULL: if (line_tx_ready && rd_idx == LAST_BYTE) st_nxt = TX_HUNT;
            default: st_nxt = TX_HUNT;
        endcase
    end

    // outputs
    always_comb begin
        tx_pull       = (st != TX_FULL);
        line_tx_valid = (st == TX_FULL);
        line_tx_data  = buf_mem[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nib_cnt <= '0;
            rd_idx  <= '0;
            hi_hold <= '0;
        end else begin
            if (tx_pull && tx_frame) begin
                nib_cnt <= '0;
            end else if (st == TX_FILL && tx_pull) begin
                if (!nib_cnt[0]) hi_hold <= tx_nib;
                nib_cnt <= (nib_cnt == LAST_NIB) ? '0 : nib_cnt + 1'b1;
            end
            if (st == TX_FULL && line_tx_ready)
                rd_idx <= (rd_idx == LAST_BYTE) ? '0 : rd_idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (st == TX_FILL && tx_pull && !tx_frame && nib_cnt[0])
            buf_mem[nib_cnt[NW-1:1]] <= {hi_hold, tx_nib};
    end
endmodule

// File: rtl/nibble_cell_rx.sv
module nibble_cell_rx
    import nibble_cell_pkg::*;
#(
    parameter int NIB_W     = 4,
    parameter int CELL_NIBS = 106
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_rx_valid,
    output logic               line_rx_ready,
    input  logic [2*NIB_W-1:0] line_rx_data,
    input  logic               rx_take,
    output logic               rx_frame,
    output logic               rx_nib_vld,
    output logic [NIB_W-1:0]   rx_nib
);
    localparam int BYTE_W     = 2 * NIB_W;
    localparam int CELL_BYTES = CELL_NIBS / 2;
    localparam int NW         = $clog2(CELL_NIBS);
    localparam int BW         = $clog2(CELL_BYTES);
    localparam logic [NW-1:0] LAST_NIB  = NW'(CELL_NIBS - 1);
    localparam logic [BW-1:0] LAST_BYTE = BW'(CELL_BYTES - 1);

    rx_state_e         st, st_nxt;
    logic [BW-1:0]     wr_idx;
    logic [NW-1:0]     nib_idx;
    logic [BYTE_W-1:0] buf_mem [CELL_BYTES];
    logic [BYTE_W-1:0] cur_byte;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= RX_LOAD;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            RX_LOAD:  if (line_rx_valid && wr_idx == LAST_BYTE) st_nxt = RX_FRAME;
            RX_FRAME: if (rx_take) st_nxt = RX_SEND;
            RX_SEND:  if (rx_take && nib_idx == LAST_NIB) st_nxt = RX_LOAD;
            default:  st_nxt = RX_LOAD;
        endcase
    end

    // outputs
    always_comb begin
        cur_byte      = buf_mem[nib_idx[NW-1:1]];
        line_rx_ready = (st == RX_LOAD);
        rx_frame      = (st == RX_FRAME) && rx_take;
        rx_nib_vld    = (st == RX_SEND) && rx_take;
        rx_nib        = '0;
        if (rx_nib_vld)
            rx_nib = nib_idx[0] ? cur_byte[NIB_W-1:0] : cur_byte[BYTE_W-1:NIB_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx  <= '0;
            nib_idx <= '0;
        end else begin
            if (st == RX_LOAD && line_rx_valid)
                wr_idx <= (wr_idx == LAST_BYTE) ? '0 : wr_idx + 1'b1;
            if (st == RX_SEND && rx_take)
                nib_idx <= (nib_idx == LAST_NIB) ? '0 : nib_idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (st == RX_LOAD && line_rx_valid)
            buf_mem[wr_idx] <= line_rx_data;
    end
endmodule

// File: rtl/nibble_cell_port.sv
module nibble_cell_port #(
    parameter int NIB_W     = 4,
    parameter int CELL_NIBS = 106
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic               tx_pull,
    input  logic               tx_frame,
    input  logic [NIB_W-1:0]   tx_nib,
    output logic               line_tx_valid,
    input  logic               line_tx_ready,
    output logic [2*NIB_W-1:0] line_tx_data,
    input  logic               line_rx_valid,
    output logic               line_rx_ready,
    input  logic [2*NIB_W-1:0] line_rx_data,
    input  logic               rx_take,
    output logic               rx_frame,
    output logic               rx_nib_vld,
    output logic [NIB_W-1:0]   rx_nib
);
    nibble_cell_tx #(.NIB_W(NIB_W), .CELL_NIBS(CELL_NIBS)) u_tx (
        .clk           (clk),
        .rst_n         (rst_n),
        .tx_pull       (tx_pull),
        .tx_frame      (tx_frame),
        .tx_nib        (tx_nib),
        .line_tx_valid (line_tx_valid),
        .line_tx_ready (line_tx_ready),
        .line_tx_data  (line_tx_data)
    );

    nibble_cell_rx #(.NIB_W(NIB_W), .CELL_NIBS(CELL_NIBS)) u_rx (
        .clk           (clk),
        .rst_n         (rst_n),
        .line_rx_valid (line_rx_valid),
        .line_rx_ready (line_rx_ready),
        .line_rx_data  (line_rx_data),
        .rx_take       (rx_take),
        .rx_frame      (rx_frame),
        .rx_nib_vld    (rx_nib_vld),
        .rx_nib        (rx_nib)
    );
endmodule

// File: rtl/nibble_cell_port_chk.sv
module nibble_cell_port_chk #(
    parameter int NIB_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tx_pull,
    input logic               line_tx_valid,
    input logic               line_tx_ready,
    input logic [2*NIB_W-1:0] line_tx_data,
    input logic               line_rx_ready,
    input logic               rx_take,
    input logic               rx_frame,
    input logic               rx_nib_vld
);
    // R4: no pulling while the buffered cell drains
    a_r4_pull_gated: assert property (@(posedge clk) disable iff (!rst_n)
        line_tx_valid |-> !tx_pull);

    // R5: stalled byte stays offered and unchanged
    a_r5_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        line_tx_valid && !line_tx_ready |=> line_tx_valid && $stable(line_tx_data));

    // R7: no frame or nibble while bytes are still being loaded
    a_r7_load_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_frame || rx_nib_vld) |-> !line_rx_ready);

    // R8: frame needs a take cycle and carries no nibble
    a_r8_frame_take: assert property (@(posedge clk) disable iff (!rst_n)
        rx_frame |-> rx_take && !rx_nib_vld);

    // R8: frame lasts one take cycle
    a_r8_frame_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_frame |=> !rx_frame);

    // R9: nothing delivered without the receive clock
    a_r9_no_take_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_take |-> !rx_nib_vld && !rx_frame);
endmodule

bind nibble_cell_port nibble_cell_port_chk #(.NIB_W(NIB_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_pull       (tx_pull),
    .line_tx_valid (line_tx_valid),
    .line_tx_ready (line_tx_ready),
    .line_tx_data  (line_tx_data),
    .line_rx_ready (line_rx_ready),
    .rx_take       (rx_take),
    .rx_frame      (rx_frame),
    .rx_nib_vld    (rx_nib_vld)
);

// File: tb/nibble_cell_port_bench.sv
`timescale 1ns/1ps
module nibble_cell_port_bench;
    localparam int NIBS  = 106;
    localparam int BYTES = 53;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_pull, tx_frame = 1'b0;
    logic [3:0] tx_nib = '0;
    logic       line_tx_valid, line_tx_ready = 1'b0;
    logic [7:0] line_tx_data;
    logic       line_rx_valid = 1'b0, line_rx_ready;
    logic [7:0] line_rx_data = '0;
    logic       rx_take = 1'b0, rx_frame, rx_nib_vld;
    logic [3:0] rx_nib;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;

    always #2 clk = ~clk;

    nibble_cell_port u_nibble_cell_port (.*);

    // seed, junk nibbles before frame
    localparam logic [7:0] SEED_TAB [4] = '{8'h00, 8'h5A, 8'hC3, 8'hFF};
    localparam int         JUNK_TAB [4] = '{0, 3, 1, 7};

    function automatic logic [7:0] cbyte(input logic [7:0] s, input int k);
        return s ^ 8'(k * 37);
    endfunction

    function automatic logic [3:0] cnib(input logic [7:0] s, input int j);
        logic [7:0] b;
        b = cbyte(s, j / 2);
        return (j % 2 == 1) ? b[3:0] : b[7:4];
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic f, input logic [3:0] n);
        @(negedge clk);
        while (!tx_pull) @(negedge clk);
        tx_frame = f;
        tx_nib   = n;
        @(posedge clk);
        #1;
        tx_frame = 1'b0;
        tx_nib   = '0;
    endtask

    task automatic send_cell(input logic [7:0] s, input int junk);
        for (int i = 0; i < junk; i++) push(1'b0, 4'hA);   // R2 junk
        push(1'b1, 4'h0);
        for (int j = 0; j < NIBS; j++) push(1'b0, cnib(s, j));
        @(negedge clk);
        chk(!tx_pull && line_tx_valid, "R4 pull off when full", tx_pull, 0);
        tx_frame = 1'b1;
        tx_nib   = 4'hF;
        repeat (3) @(negedge clk);
        tx_frame = 1'b0;
        tx_nib   = '0;
    endtask

    task automatic drain_cell(input logic [7:0] s);
        int k = 0;
        int n = 0;
        logic [7:0] held;
        while (k < BYTES) begin
            @(negedge clk);
            line_tx_ready = (n % 3 != 2);
            n++;
            if (line_tx_valid) begin
                if (line_tx_ready) begin
                    chk(line_tx_data == cbyte(s, k), "R3 byte content", line_tx_data, cbyte(s, k));
                    k++;
                end else begin
                    held = line_tx_data;
                    @(negedge clk);
                    chk(line_tx_valid && line_tx_data == held, "R5 hold", line_tx_data, held);
                end
            end
        end
        @(negedge clk);
        line_tx_ready = 1'b0;
        chk(tx_pull && !line_tx_valid, "R5 drained, R4 pull back", tx_pull, 1);
    endtask

    task automatic load_cell(input logic [7:0] s);
        for (int k = 0; k < BYTES; k++) begin
            @(negedge clk);
            line_rx_valid = 1'b1;
            line_rx_data  = cbyte(s, k);
            if (k == 20) begin
                rx_take = 1'b1;
                #1;
                chk(!rx_frame && !rx_nib_vld, "R8 no frame before full", rx_frame, 0);
            end
            @(posedge clk);
            #1;
            rx_take = 1'b0;
        end
        @(negedge clk);
        line_rx_data = 8'h00;  // offered while not ready: ignored
        chk(!line_rx_ready, "R7 ready drops when full", line_rx_ready, 0);
    endtask

    task automatic unload_cell(input logic [7:0] s);
        @(negedge clk);
        line_rx_valid = 1'b0;
        #1;
        chk(!rx_frame, "R8 no frame without take", rx_frame, 0);
        @(negedge clk);
        rx_take = 1'b1;
        #1;
        chk(rx_frame && !rx_nib_vld, "R8 frame pulse", rx_frame, 1);
        @(posedge clk);
        #1;
        rx_take = 1'b0;
        for (int j = 0; j < NIBS; j++) begin
            if (j % 5 == 4) begin
                @(negedge clk);
                #1;
                chk(!rx_nib_vld && !rx_frame, "R9 no take no advance", rx_nib_vld, 0);
            end
            @(negedge clk);
            rx_take = 1'b1;
            #1;
            chk(rx_nib_vld && rx_nib == cnib(s, j), "R9 nibble", rx_nib, cnib(s, j));
            chk(!rx_frame, "R8 single frame", rx_frame, 0);
            @(posedge clk);
            #1;
            rx_take = 1'b0;
        end
        @(negedge clk);
        chk(line_rx_ready, "R10 ready returns", line_rx_ready, 1);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(tx_pull && line_rx_ready, "R1 reset pull/ready", {tx_pull, line_rx_ready}, 3);
        chk(!line_tx_valid && !rx_frame && !rx_nib_vld, "R1 reset quiet",
            {line_tx_valid, rx_frame, rx_nib_vld}, 0);
        rst_n = 1'b1;

        for (int v = 0; v < 4; v++) begin
            send_cell(SEED_TAB[v], JUNK_TAB[v]);   // R2, R3, R4
            drain_cell(SEED_TAB[v]);              // R3, R5
            load_cell(SEED_TAB[v] ^ 8'h3C);       // R7, R8
            unload_cell(SEED_TAB[v] ^ 8'h3C);     // R8, R9, R10
        end

        // R6: second frame mid-cell restarts alignment
        push(1'b1, 4'h0);
        for (int i = 0; i < 11; i++) push(1'b0, 4'h7);
        send_cell(8'h96, 0);
        drain_cell(8'h96);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule